// File: doc/BRIEF.md
# Overlapping Latched Multiphase On-Off Controller

This block drives the gate enables of a multiphase switching regulator from a single regulation comparator. A rotating slot sequencer hands out one start pulse per slot, visiting the phases in a fixed order. Every phase therefore receives a start pulse at the same fixed rate, whatever the load. A start pulse turns its phase on only while the synchronized comparator reports that the output is still below the reference. Once on, a phase stays latched, even past the end of its own slot. When the comparator reports that the reference has been reached, every conducting phase is released on the same clock edge.

Under light load, a phase switches off before the next slot begins. Under heavy load, the on-times run into later slots, so several phases conduct at once. The duty cycle of each phase varies while its switching frequency stays fixed. An active-phase count is provided so that the amount of overlap can be seen directly.

Top module: `multiphase_latch_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every gate enable is 0 and the active count is 0. The sequencer restarts so that the first start pulse after reset goes to phase 0.
- R2: Start pulses rotate through phases 0, 1, ..., NUM_PHASES-1 and then wrap around. Consecutive pulses are SLOT_CYCLES clocks apart, so each phase gets a pulse every NUM_PHASES*SLOT_CYCLES clocks. At most one pulse is present in any cycle.
- R3: A gate enable rises only on the clock edge that follows a start pulse for that same phase, and only if the synchronized comparator level was high in that cycle.
- R4: While the synchronized comparator level is high, a gate that is on stays on, including through the slots of other phases.
- R5: When the synchronized comparator level is low, all gates are 0 after the next clock edge. Gates that were conducting together are released on the same edge.
- R6: A start pulse that arrives while the synchronized comparator level is low has no effect: the phase stays off.
- R7: The comparator input passes through two flip-flops. A change on `comp_below` first affects the gates at the third rising edge after it is applied.
- R8: `active_count` equals the number of gate enables that are 1. Any number of phases, up to all of them, may be on at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_below | input | 1 | Comparator level, 1 while the output is below the reference (asynchronous) |
| gate_en | output | NUM_PHASES | Per-phase gate enable, bit i drives phase i |
| active_count | output | $clog2(NUM_PHASES+1) | Number of phases currently on |

## Verification
The comparator is driven with a table of level segments, and a cycle-level model checks the outputs on every cycle.
- Short high pulses of one to seven cycles separate light load, where a phase latches and drops inside its own slot, from start pulses that are ignored.
- Long high runs pile up overlapping phases until all of them conduct. This separates correct holding from early release.
- Directed tests cover three further cases. They record the edge on which each phase first rises, to confirm the rotation order and spacing. They hold the comparator low for a full period to show that every pulse is ignored. They drop the comparator under full overlap to show the common release on exactly the third edge.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

  // Count the ones in a phase vector (zero-extended to 32 bits).
  function automatic int unsigned ones_in(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // Next phase index in the rotation.
  function automatic int unsigned next_phase(input int unsigned cur, input int unsigned n_ph);
    return (cur + 1 >= n_ph) ? 0 : cur + 1;
  endfunction

  // Latch rule: set by start, held while below, cleared otherwise.
  function automatic logic latch_next(input logic cur, input logic start, input logic below);
    return (cur | start) & below;
  endfunction

endpackage

// File: rtl/mlc_sync2.sv
module mlc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;
endmodule

// File: rtl/mlc_slot_seq.sv
module mlc_slot_seq #(
  parameter int NUM_PHASES  = 5,
  parameter int SLOT_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [NUM_PHASES-1:0] start_vec
);
  import mlc_pkg::*;

  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam int PW = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cyc_q;
  logic [PW-1:0] ph_q;
  logic          slot_end;

  assign slot_end = (cyc_q == CYC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ph_q  <= '0;
    end else if (slot_end) begin
      cyc_q <= '0;
      ph_q  <= PW'(next_phase(int'(ph_q), NUM_PHASES));
    end else begin
      cyc_q <= cyc_q + CW'(1);
    end
  end

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_start
    assign start_vec[i] = (cyc_q == '0) && (ph_q == PW'(i));
  end
endmodule

// File: rtl/mlc_phase_latch.sv
module mlc_phase_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic below,
  output logic gate
);
  import mlc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= latch_next(gate, start, below);
  end
endmodule

// File: rtl/multiphase_latch_ctrl.sv
module multiphase_latch_ctrl #(
  parameter int NUM_PHASES  = 5,
  parameter int SLOT_CYCLES = 4,
  localparam int CNT_W      = $clog2(NUM_PHASES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  comp_below,
  output logic [NUM_PHASES-1:0] gate_en,
  output logic [CNT_W-1:0]      active_count
);
  import mlc_pkg::*;

  // Internal events brought out for the checker.
  logic [NUM_PHASES-1:0] start_vec;
  logic                  below_sync;

  mlc_sync2 u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(comp_below),
    .q_sync (below_sync)
  );

  mlc_slot_seq #(
    .NUM_PHASES (NUM_PHASES),
    .SLOT_CYCLES(SLOT_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_vec(start_vec)
  );

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
    mlc_phase_latch u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start_vec[i]),
      .below(below_sync),
      .gate (gate_en[i])
    );
  end

  assign active_count = CNT_W'(ones_in(32'(gate_en)));
endmodule

// File: rtl/multiphase_latch_ctrl_chk.sv
module multiphase_latch_ctrl_chk #(
  parameter int NUM_PHASES = 5,
  parameter int CNT_W      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PHASES-1:0] gate_en,
  input logic [CNT_W-1:0]      active_count,
  input logic [NUM_PHASES-1:0] start_vec,
  input logic                  below_sync
);
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_vec)); // R2

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_rise
    AST_RISE_ON_OWN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en[i]) |-> ($past(start_vec[i]) && $past(below_sync))); // R3
  end

  AST_HOLD_WHILE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    below_sync |=> ((gate_en & $past(gate_en)) == $past(gate_en))); // R4

  AST_RELEASE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !below_sync |=> (gate_en == '0)); // R5

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    active_count == CNT_W'($countones(gate_en))); // R8
endmodule

bind multiphase_latch_ctrl multiphase_latch_ctrl_chk #(
  .NUM_PHASES(NUM_PHASES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_en     (gate_en),
  .active_count(active_count),
  .start_vec   (start_vec),
  .below_sync  (below_sync)
);

// File: tb/multiphase_latch_ctrl_bench.sv
`timescale 1ns/1ps
module multiphase_latch_ctrl_bench;
  localparam int NP = 5;
  localparam int SC = 4;
  localparam int CW = $clog2(NP + 1);
  localparam int NSEG = 10;
  // Each entry: {comparator level, cycles to hold}
  localparam logic [8:0] SEG [NSEG] = '{
    {1'b0, 8'd10}, {1'b1, 8'd30}, {1'b0, 8'd5}, {1'b1, 8'd7}, {1'b0, 8'd3},
    {1'b1, 8'd60}, {1'b0, 8'd2}, {1'b1, 8'd1}, {1'b0, 8'd4}, {1'b1, 8'd25}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic comp_below = 1'b0;
  logic [NP-1:0] gate_en;
  logic [CW-1:0] active_count;

  int checks = 0;
  int fails = 0;
  int m_cyc, m_ph;
  logic m_s1, m_s2;
  logic [NP-1:0] m_gate;

  always #5 clk = ~clk;

  multiphase_latch_ctrl #(.NUM_PHASES(NP), .SLOT_CYCLES(SC)) u_multiphase_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .comp_below(comp_below),
    .gate_en(gate_en), .active_count(active_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    comp_below = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 gates in reset", int'(gate_en), 0);
    check("R1 count in reset", int'(active_count), 0);
    rst_n = 1'b1;
    m_cyc = 0; m_ph = 0; m_s1 = 0; m_s2 = 0; m_gate = '0;
  endtask

  // One clock of stimulus, followed by a comparison against the bench model.
  task automatic step(input logic comp);
    logic [NP-1:0] st, ng;
    int n_ones;
    comp_below = comp;
    st = (m_cyc == 0) ? NP'(1) << m_ph : '0;
    ng = (m_gate | st) & {NP{m_s2}};
    @(posedge clk);
    #1;
    m_gate = ng;
    m_s2 = m_s1;
    m_s1 = comp;
    if (m_cyc == SC - 1) begin
      m_cyc = 0;
      m_ph = (m_ph == NP - 1) ? 0 : m_ph + 1;
    end else m_cyc++;
    check("R3/R4/R5/R6/R7 gates", int'(gate_en), int'(m_gate));
    n_ones = $countones(m_gate);
    check("R8 count", int'(active_count), n_ones);
  endtask

  initial begin : watchdog
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int first_rise [NP];

    // R1 and R6: after reset, a comparator held low for a full period ignores every start pulse.
    do_reset();
    for (int k = 0; k < NP * SC + 2; k++) step(1'b0);
    check("R6 no phase on", int'(gate_en), 0);

    // Table-driven walk; the model is checked on every cycle.
    do_reset();
    for (int s = 0; s < NSEG; s++)
      for (int k = 0; k < int'(SEG[s][7:0]); k++) step(SEG[s][8]);

    // R2: record the edge on which each phase first rises, with the comparator held high.
    do_reset();
    for (int i = 0; i < NP; i++) first_rise[i] = -1;
    for (int e = 0; e < NP * SC + 4; e++) begin
      step(1'b1);
      for (int i = 0; i < NP; i++)
        if (gate_en[i] && first_rise[i] < 0) first_rise[i] = e;
    end
    // The first pulse (phase 0, edge 0) falls before sync settles.
    // Phase i (i>=1) rises at edge i*SC; phase 0 rises at edge NP*SC.
    for (int i = 1; i < NP; i++) check("R2 phase order", first_rise[i], i * SC);
    check("R2 phase 0 wrap", first_rise[0], NP * SC);
    check("R8 all phases overlap", int'(active_count), NP);

    // R7 and R5: drop the comparator under full overlap; release comes on the third edge.
    step(1'b0);
    check("R7 held after edge 1", int'(gate_en), (1 << NP) - 1);
    step(1'b0);
    check("R7 held after edge 2", int'(gate_en), (1 << NP) - 1);
    step(1'b0);
    check("R5 all released together", int'(gate_en), 0);
    check("R8 count zero after release", int'(active_count), 0);

    // R1: reset taken in mid-run clears everything.
    step(1'b1);
    rst_n = 1'b0;
    #2;
    check("R1 async clear", int'(gate_en), 0);
    do_reset();
    step(1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule